// File: doc/BRIEF.md
# Bus-clocked wiper step controller

This block runs the fine-adjust phase of a serial-controlled dual potentiometer. The command decoder pulses `step_en` once the increment/decrement instruction byte has been acknowledged, and gives the wiper index with it. From then on the block ignores byte framing and reads the synchronised bus lines directly. Each high pulse of SCL is one step. The level of SDA at the SCL rising edge picks the direction: high moves toward the high terminal (+1), low moves toward the low terminal (-1). The step is committed when SCL falls again. This way the SCL-high phase that carries a START or STOP never moves a wiper.

The block does not own the volatile wiper registers. It reads their current values on `wcr_cur` and returns a write strobe and a new value per wiper on `wcr_we`/`wcr_nxt`. The register owner applies them. Stored (non-volatile) settings are never touched. The block never drives SDA, so no acknowledge is produced in this mode.

The controller is a four-state machine:
- `WS_IDLE`: not in the mode. `step_en` without a bus condition leads to `WS_WAIT_LOW` when SCL is high, or to `WS_ARMED` when SCL is low.
- `WS_WAIT_LOW`: wait for SCL to go low, so a pulse already in progress at entry is not counted. SCL low leads to `WS_ARMED`.
- `WS_ARMED`: SCL is low, waiting for a pulse. An SCL rising edge captures SDA as the direction and leads to `WS_HELD`.
- `WS_HELD`: SCL is high. An SCL falling edge fires the step and returns to `WS_ARMED`.

From any state other than `WS_IDLE`, a START or STOP strobe returns to `WS_IDLE` at once and drops any pending step.

Top module: `wiper_step_ctrl`

## Requirements
- R1: After reset `stepping` is 0 and `wcr_we` is all zeros.
- R2: A `step_en` pulse in idle with no START/STOP strobe in the same cycle sets `stepping` from the next clock. It also latches `pot_sel` (0 selects wiper 0 at `wcr_cur[5:0]`, 1 selects wiper 1 at `wcr_cur[11:6]`).
- R3: In the mode, an SCL high pulse with SDA high at the rising edge gives one `wcr_we` strobe for the selected wiper, with `wcr_nxt` equal to its current value plus 1. The strobe is one clock wide and is visible after the first clock edge that samples SCL low.
- R4: The same pulse with SDA low at the rising edge gives the current value minus 1.
- R5: An increment at 63 writes 63 (no wrap to 0).
- R6: A decrement at 0 writes 0 (no wrap to 63).
- R7: A STOP strobe ends the mode (`stepping` is 0 on the next clock), and the SCL high phase it occurs in produces no step.
- R8: A START strobe ends the mode in the same way, and the pulse in progress produces no step.
- R9: At most one `wcr_we` bit is set at a time, and only the selected wiper is written. The other wiper keeps its value.
- R10: Outside the mode, SCL pulses produce no write.
- R11: On entry while SCL is high, the falling edge of that high phase produces no step; only later full pulses count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_en | input | 1 | One-cycle start of stepping mode from the command decoder |
| pot_sel | input | PSEL_W (1) | Wiper index captured with `step_en` |
| scl_s | input | 1 | Synchronised SCL level |
| sda_s | input | 1 | Synchronised SDA level |
| start_det | input | 1 | One-cycle START condition strobe |
| stop_det | input | 1 | One-cycle STOP condition strobe |
| wcr_cur | input | NPOT*W (12) | Current wiper register values, wiper i at bits [i*W +: W] |
| stepping | output | 1 | High while the stepping mode is active |
| wcr_we | output | NPOT (2) | One-cycle write strobe per wiper |
| wcr_nxt | output | NPOT*W (12) | New value per wiper, valid with its strobe |

## Verification
`stepping` follows the state register, so it changes one clock after the `step_en`, START or STOP strobe is sampled. A step strobe follows one clock after the first edge that samples SCL low at the end of a pulse. The bench holds a behavioural model that is advanced at every rising clock edge from the same input values the design samples. It compares `stepping`, `wcr_we` and `wcr_nxt` at the following falling edge, when all of these have settled. Directed checks on the wiper values read the bench-owned registers a few clocks after each pulse or bus condition. By then every strobe due from that stimulus has been applied.

// File: rtl/wstep_pkg.sv
package wstep_pkg;

    typedef enum logic [1:0] {
        WS_IDLE     = 2'd0,
        WS_WAIT_LOW = 2'd1,
        WS_ARMED    = 2'd2,
        WS_HELD     = 2'd3
    } wstep_state_e;

endpackage

// File: rtl/wstep_edge.sv
module wstep_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_q;

    // Bus idles high, so the history register resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
        end
    end

    always_comb begin
        scl_rise = scl_s & ~scl_q;
        scl_fall = ~scl_s & scl_q;
    end

endmodule

// File: rtl/wstep_fsm.sv
module wstep_fsm
    import wstep_pkg::*;
#(
    parameter int PSEL_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [PSEL_W-1:0] pot_sel,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              stepping,
    output logic              fire,
    output logic              fire_up,
    output logic [PSEL_W-1:0] fire_pot
);

    wstep_state_e      state_q;
    wstep_state_e      state_d;
    logic [PSEL_W-1:0] pot_q;
    logic              up_q;
    logic              ld_pot;
    logic              cap_dir;
    logic              bus_exit;

    assign bus_exit = start_det | stop_det;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            pot_q   <= '0;
            up_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ld_pot) begin
                pot_q <= pot_sel;
            end
            if (cap_dir) begin
                up_q <= sda_s;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        ld_pot  = 1'b0;
        cap_dir = 1'b0;
        unique case (state_q)
            WS_IDLE: begin
                if (step_en && !bus_exit) begin
                    ld_pot  = 1'b1;
                    state_d = scl_s ? WS_WAIT_LOW : WS_ARMED;
                end
            end
            WS_WAIT_LOW: begin
                if (bus_exit) begin
                    state_d = WS_IDLE;
                end else if (!scl_s) begin
                    state_d = WS_ARMED;
                end
            end
            WS_ARMED: begin
                if (bus_exit) begin
                    state_d = WS_IDLE;
                end else if (scl_rise) begin
                    cap_dir = 1'b1;
                    state_d = WS_HELD;
                end
            end
            WS_HELD: begin
                if (bus_exit) begin
                    state_d = WS_IDLE;
                end else if (scl_fall) begin
                    state_d = WS_ARMED;
                end
            end
            default: state_d = WS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        stepping = (state_q != WS_IDLE);
        fire     = (state_q == WS_HELD) && scl_fall && !bus_exit;
        fire_up  = up_q;
        fire_pot = pot_q;
    end

    AST_ENTRY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stepping) |-> $past(step_en)); // R2

    AST_STOP_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && stepping) |=> !stepping); // R7

    AST_START_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && stepping) |=> !stepping); // R8

    AST_FIRE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (!scl_s && $past(scl_s))); // R3

endmodule

// File: rtl/wstep_wiper.sv
module wstep_wiper #(
    parameter int W      = 6,
    parameter int IDX    = 0,
    parameter int PSEL_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              fire_up,
    input  logic [PSEL_W-1:0] fire_pot,
    input  logic [W-1:0]      cur,
    output logic              we,
    output logic [W-1:0]      nxt
);

    localparam logic [W-1:0] TOP_TAP = '1;
    localparam logic [W-1:0] BOT_TAP = '0;

    logic         mine;
    logic [W-1:0] moved;

    assign mine = fire && (fire_pot == PSEL_W'(IDX));

    // Saturating one-tap move
    always_comb begin
        if (fire_up) begin
            moved = (cur == TOP_TAP) ? cur : cur + W'(1);
        end else begin
            moved = (cur == BOT_TAP) ? cur : cur - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we  <= 1'b0;
            nxt <= '0;
        end else begin
            we <= mine;
            if (mine) begin
                nxt <= moved;
            end
        end
    end

    AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (nxt == $past(cur) || nxt == $past(cur) + W'(1)
                || nxt == $past(cur) - W'(1))); // R3

    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (we && $past(cur) == TOP_TAP) |-> (nxt != BOT_TAP)); // R5

    AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && $past(cur) == BOT_TAP) |-> (nxt != TOP_TAP)); // R6

endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl #(
    parameter int NPOT = 2,
    parameter int W    = 6,
    localparam int PSEL_W = (NPOT > 1) ? $clog2(NPOT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic [PSEL_W-1:0]   pot_sel,
    input  logic                scl_s,
    input  logic                sda_s,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic [NPOT*W-1:0]   wcr_cur,
    output logic                stepping,
    output logic [NPOT-1:0]     wcr_we,
    output logic [NPOT*W-1:0]   wcr_nxt
);

    logic              scl_rise;
    logic              scl_fall;
    logic              fire;
    logic              fire_up;
    logic [PSEL_W-1:0] fire_pot;

    wstep_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    wstep_fsm #(.PSEL_W(PSEL_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .pot_sel   (pot_sel),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .stepping  (stepping),
        .fire      (fire),
        .fire_up   (fire_up),
        .fire_pot  (fire_pot)
    );

    for (genvar i = 0; i < NPOT; i++) begin : g_wiper
        wstep_wiper #(.W(W), .IDX(i), .PSEL_W(PSEL_W)) u_wiper (
            .clk      (clk),
            .rst_n    (rst_n),
            .fire     (fire),
            .fire_up  (fire_up),
            .fire_pot (fire_pot),
            .cur      (wcr_cur[i*W +: W]),
            .we       (wcr_we[i]),
            .nxt      (wcr_nxt[i*W +: W])
        );
    end

    AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wcr_we)); // R9

    AST_WRITE_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (|wcr_we) |-> $past(stepping)); // R10

endmodule

// File: tb/sim_wiper_step_ctrl.sv
module sim_wiper_step_ctrl;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_en;
    logic [0:0]  pot_sel;
    logic        scl;
    logic        sda;
    logic        start_det;
    logic        stop_det;
    logic [11:0] wcr_cur;
    logic        stepping;
    logic [1:0]  wcr_we;
    logic [11:0] wcr_nxt;

    int checks = 0;
    int errors = 0;

    // bench-owned wiper registers
    logic [5:0] wreg [2];
    bit         pre_go = 1'b0;
    int         pre_pot = 0;
    int         pre_val = 0;

    // reference model state
    bit m_on, m_wait, m_high, m_dir, m_prev;
    int m_pot;
    bit [1:0] e_we;
    int e_nxt [2];

    always #(CLK_P/2) clk = ~clk;

    assign wcr_cur = {wreg[1], wreg[0]};

    wiper_step_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .pot_sel(pot_sel),
        .scl_s(scl), .sda_s(sda), .start_det(start_det), .stop_det(stop_det),
        .wcr_cur(wcr_cur), .stepping(stepping), .wcr_we(wcr_we), .wcr_nxt(wcr_nxt)
    );

    function automatic int step_val(int v, bit up);
        if (up) return (v < 63) ? v + 1 : 63;
        return (v > 0) ? v - 1 : 0;
    endfunction

    // behavioural model, advanced on the same edge the design samples
    always @(posedge clk or negedge rst_n) begin
        e_we = 2'b00;
        if (!rst_n) begin
            m_on = 0; m_wait = 0; m_high = 0; m_dir = 0; m_prev = 1; m_pot = 0;
            e_nxt[0] = 0; e_nxt[1] = 0;
        end else begin
            if (m_on) begin
                if (start_det || stop_det) m_on = 0;
                else if (m_wait) begin
                    if (!scl) m_wait = 0;
                end else if (!m_high) begin
                    if (scl && !m_prev) begin m_high = 1; m_dir = sda; end
                end else if (!scl && m_prev) begin
                    m_high = 0;
                    e_we[m_pot] = 1'b1;
                    e_nxt[m_pot] = step_val(wreg[m_pot], m_dir);
                end
            end else if (step_en && !start_det && !stop_det) begin
                m_on = 1; m_wait = scl; m_high = 0; m_pot = pot_sel;
            end
            m_prev = scl;
        end
    end

    // every-cycle comparison, and the only writer of the wiper registers
    initial begin wreg[0] = 6'd10; wreg[1] = 6'd40; end
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (stepping !== m_on) begin
                errors++;
                $display("FAIL R2 stepping: actual %0b expected %0b", stepping, m_on);
            end
            checks++;
            if (wcr_we !== e_we) begin
                errors++;
                $display("FAIL R9 wcr_we: actual %b expected %b", wcr_we, e_we);
            end
            for (int i = 0; i < 2; i++) begin
                if (e_we[i]) begin
                    checks++;
                    if (wcr_nxt[i*6 +: 6] !== 6'(e_nxt[i])) begin
                        errors++;
                        $display("FAIL R3 wcr_nxt[%0d]: actual %0d expected %0d",
                                 i, wcr_nxt[i*6 +: 6], e_nxt[i]);
                    end
                    wreg[i] = 6'(e_nxt[i]);
                end
            end
        end
        if (pre_go) wreg[pre_pot] = 6'(pre_val);
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse(bit d);
        sda = d; tick(2);
        scl = 1'b1; tick(3);
        scl = 1'b0; tick(3);
    endtask

    task automatic enter(bit p);
        pot_sel = p; step_en = 1'b1; tick(1);
        step_en = 1'b0; tick(1);
    endtask

    task automatic bus_stop();
        sda = 1'b0; tick(1);
        scl = 1'b1; tick(2);
        sda = 1'b1; stop_det = 1'b1; tick(1);
        stop_det = 1'b0; tick(2);
    endtask

    task automatic bus_start();
        sda = 1'b1; tick(1);
        scl = 1'b1; tick(2);
        sda = 1'b0; start_det = 1'b1; tick(1);
        start_det = 1'b0; tick(1);
        scl = 1'b0; tick(2);
    endtask

    task automatic preset(int p, int v);
        pre_pot = p; pre_val = v; pre_go = 1'b1; tick(1);
        pre_go = 1'b0; tick(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; step_en = 1'b0; pot_sel = 1'b0; scl = 1'b1; sda = 1'b1;
        start_det = 1'b0; stop_det = 1'b0;
        tick(4);
        rst_n = 1'b1; tick(1);
        chk("R1 stepping after reset", int'(stepping), 0);
        chk("R1 wcr_we after reset", int'(wcr_we), 0);

        scl = 1'b0; tick(2);
        enter(1'b0);
        chk("R2 mode entered", int'(stepping), 1);
        pulse(1); pulse(1); pulse(1);
        chk("R3 three increments", int'(wreg[0]), 13);
        pulse(0); pulse(0);
        chk("R4 two decrements", int'(wreg[0]), 11);
        chk("R9 other wiper untouched", int'(wreg[1]), 40);
        bus_stop();
        chk("R7 mode left at stop", int'(stepping), 0);
        chk("R7 no step from stop phase", int'(wreg[0]), 11);

        enter(1'b1);
        scl = 1'b0; tick(2);
        chk("R11 entry pulse not counted", int'(wreg[1]), 40);
        pulse(1);
        chk("R11 later pulse counted", int'(wreg[1]), 41);
        bus_start();
        chk("R8 mode left at start", int'(stepping), 0);
        chk("R8 no step from start pulse", int'(wreg[1]), 41);

        pulse(1); pulse(0);
        chk("R10 idle pulses ignored w0", int'(wreg[0]), 11);
        chk("R10 idle pulses ignored w1", int'(wreg[1]), 41);

        preset(1, 62);
        enter(1'b1);
        pulse(1); pulse(1); pulse(1);
        chk("R5 saturate at 63", int'(wreg[1]), 63);
        bus_stop();

        preset(0, 1);
        scl = 1'b0; tick(2);
        enter(1'b0);
        pulse(0); pulse(0); pulse(0);
        chk("R6 saturate at 0", int'(wreg[0]), 0);
        pulse(1); pulse(0); pulse(1);
        chk("R3 mixed directions", int'(wreg[0]), 1);
        chk("R9 wiper 1 held", int'(wreg[1]), 63);
        bus_stop();
        chk("R7 final stop", int'(stepping), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule